// File: doc/BRIEF.md
# Four-instruction accumulator processor

This block is a small processor core built around one 8-bit accumulator and one carry flag. Code, data and a single input/output location all sit in a 64-byte address space. Every instruction is one byte: the top two bits give the operation and the low six bits give an operand address. The ALU has only two functions, bitwise NOR and binary addition. A store instruction and a conditional jump complete the set.

The core reads and writes through a synchronous memory port. A read returns data on the cycle after the address is presented. Each instruction takes three cycles:

- a fetch cycle, which presents the program counter;
- a load cycle, which captures the instruction byte, advances the counter and presents the operand address;
- an execute cycle, which uses the operand or performs the store.

The top address, 0x3F, is not backed by the memory for operands. Operand reads at 0x3F return the input port, and stores to 0x3F drive a registered output port. A halt input parks the core at the start of an instruction.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the core presents address 0 with `mem_we` low, and `out_port` is 0. Execution begins at address 0 with the accumulator and carry cleared.
- R2: Each instruction takes exactly three cycles. The fetch cycle presents the PC. The load cycle presents the operand address, which is bits [5:0] of the fetched byte. The execute cycle presents the same operand address. The PC advances by one during the load cycle.
- R3: Opcode bits [7:6] = 00 (NOR) set the accumulator to the bitwise NOR of the accumulator and the operand. The carry flag is left unchanged.
- R4: Opcode 01 (ADD) adds the operand to the accumulator modulo 256. It sets the carry to the ninth bit of the sum.
- R5: Opcode 10 (STA) writes the accumulator to the operand address. `mem_we` is high only in the execute cycle of a store to an address other than 0x3F, and `mem_wdata` then equals the accumulator.
- R6: Opcode 11 (JCC) loads the PC with the operand address when the carry is 0 and falls through when it is 1. In both cases the carry is 0 afterwards.
- R7: NOR and ADD take their operand from `in_port` when the address is 0x3F, and from `mem_rdata` otherwise.
- R8: A store to 0x3F updates `out_port` on the execute edge and does not assert `mem_we`. No other event changes `out_port`.
- R9: While `halt` is high, the core stays in its fetch cycle with the PC, accumulator and carry unchanged, and it makes no write. An instruction already in progress completes.
- R10: The PC counts modulo 64, so execution continues at address 0 after address 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 1 | Hold the core at the next instruction boundary |
| in_port | input | 8 | Value returned by operand reads of 0x3F |
| out_port | output | 8 | Register written by stores to 0x3F |
| mem_addr | output | 6 | Memory address for this cycle |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Read data for the address presented one cycle earlier |

## Verification
The hardest case to reach from the ports is the conditional jump falling through. The carry must be set at that moment, and only an ADD that overflows sets it, so the stimulus places an overflowing addition directly before the jump. A store placed after the jump then proves the fall-through, and a later self-jump proves that the carry was cleared. The wrap from 63 to 0 also needs a program that jumps near the top of memory and keeps executing across the boundary. Random memory images, with `halt` and the input port also randomised, then cover mixed instruction sequences against a per-cycle instruction model.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 6,
  parameter int DW = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic [DW-1:0] in_port,
  output logic [DW-1:0] out_port,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [AW-1:0] IO_ADDR = '1;

  typedef enum logic [1:0] {S_FETCH, S_LOAD, S_EXEC} phase_t;

  phase_t        state;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, acc, out_q;
  logic          cy;

  wire [1:0]    op      = ir[DW-1:DW-2];
  wire [AW-1:0] opa     = ir[AW-1:0];
  wire          is_io   = (opa == IO_ADDR);
  wire [DW-1:0] operand = is_io ? in_port : mem_rdata;
  wire [DW:0]   sum     = {1'b0, acc} + {1'b0, operand};

  assign mem_addr  = (state == S_FETCH) ? pc :
                     (state == S_LOAD)  ? mem_rdata[AW-1:0] : opa;
  assign mem_we    = (state == S_EXEC) && (op == 2'b10) && !is_io;
  assign mem_wdata = acc;
  assign out_port  = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
      cy    <= 1'b0;
      out_q <= '0;
    end else begin
      unique case (state)
        S_FETCH: if (!halt) state <= S_LOAD;
        S_LOAD: begin
          ir    <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_EXEC;
        end
        default: begin
          unique case (op)
            2'b00: acc <= ~(acc | operand);
            2'b01: {cy, acc} <= sum;
            2'b10: if (is_io) out_q <= acc;
            default: begin
              if (!cy) pc <= opa;
              cy <= 1'b0;
            end
          endcase
          state <= S_FETCH;
        end
      endcase
    end
  end

  // R5
  we_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(state) == S_LOAD);

  // R8
  out_only_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_port) |-> $past(state == S_EXEC && op == 2'b10));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && halt) |=>
      (state == S_FETCH && $stable(pc) && $stable(acc) && $stable(cy)));

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD) |=> pc == $past(pc) + AW'(1));

  // R6
  jcc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && op == 2'b11) |=> !cy);

  // R4
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && op == 2'b01) |=>
      {cy, acc} == $past({1'b0, acc}) + $past({1'b0, operand}));
endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;
  logic       clk = 0, rst_n = 0, halt = 0;
  logic [7:0] in_port = 0, out_port, mem_wdata, mem_rdata;
  logic [5:0] mem_addr;
  logic       mem_we;
  int checks = 0, errors = 0;

  logic [7:0] mem [64];
  logic [7:0] ref_mem [64];
  logic [5:0] rpc;
  logic [7:0] racc, rir, rout;
  logic       rcy;
  int         rph;

  always #10 clk = ~clk;

  acc_cpu i_acc_cpu (.clk(clk), .rst_n(rst_n), .halt(halt), .in_port(in_port),
    .out_port(out_port), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference instruction model, one step per clock
  always @(negedge clk) begin
    if (!rst_n) begin
      rpc = 0; racc = 0; rcy = 0; rph = 0; rout = 0; rir = 0;
    end else begin
      logic [5:0] a;
      logic [7:0] opd;
      a = rir[5:0];
      chk(mem_addr == ((rph == 0) ? rpc : a), "R2", {2'b0, mem_addr}, {2'b0, (rph == 0) ? rpc : a});
      if (rph == 2 && rir[7:6] == 2'b10 && a != 6'h3F)
        chk(mem_we && mem_wdata == racc, "R5", mem_wdata, racc);
      else
        chk(!mem_we, "R5", {7'b0, mem_we}, 8'h00);
      chk(out_port == rout, "R8", out_port, rout);
      case (rph)
        0: if (!halt) begin rir = ref_mem[rpc]; rpc = rpc + 1; rph = 1; end
        1: rph = 2;
        default: begin
          opd = (a == 6'h3F) ? in_port : ref_mem[a];
          case (rir[7:6])
            2'b00: racc = ~(racc | opd);
            2'b01: {rcy, racc} = {1'b0, racc} + {1'b0, opd};
            2'b10: if (a == 6'h3F) rout = racc; else ref_mem[a] = racc;
            default: begin if (!rcy) rpc = a; rcy = 0; end
          endcase
          rph = 0;
        end
      endcase
    end
  end

  task automatic put(input int adr, input logic [7:0] v);
    mem[adr] = v; ref_mem[adr] = v;
  endtask

  task automatic begin_prog();
    @(posedge clk); #2; rst_n = 0; halt = 0;
    for (int i = 0; i < 64; i++) put(i, 8'h00);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    chk(mem_addr == 0 && !mem_we && out_port == 0, "R1", {2'b0, mem_addr}, 8'h00);
    @(posedge clk); #2; rst_n = 1;
    @(negedge clk);
    chk(mem_addr == 0 && out_port == 0, "R1", out_port, 8'h00);
    repeat (n) @(posedge clk);
    #2; halt = 1;
    repeat (6) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] held;
    // NOR then store, then self-jump
    begin_prog();
    put(0, 8'h0A); put(1, 8'h94); put(2, 8'hC2); put(10, 8'h5A);
    run(60);
    chk(mem[20] == 8'hA5, "R3", mem[20], 8'hA5);
    held = mem_addr;
    repeat (5) @(posedge clk);
    #2;
    chk(mem_addr == held && !mem_we, "R9", {2'b0, mem_addr}, {2'b0, held});

    // ADD with carry, jump falls through, then carry clear makes loop taken
    begin_prog();
    put(0, 8'h4A); put(1, 8'h4B); put(2, 8'h94); put(3, 8'hC0);
    put(4, 8'h95); put(5, 8'hC5); put(6, 8'h96);
    put(10, 8'hF0); put(11, 8'h20);
    run(80);
    chk(mem[20] == 8'h10, "R4", mem[20], 8'h10);
    chk(mem[21] == 8'h10, "R6", mem[21], 8'h10);
    chk(mem[22] == 8'h00, "R6", mem[22], 8'h00);

    // I/O location
    begin_prog();
    in_port = 8'h0F;
    put(0, 8'h3F); put(1, 8'hBF); put(2, 8'h9E); put(3, 8'hC3); put(63, 8'h77);
    run(60);
    chk(out_port == 8'hF0, "R8", out_port, 8'hF0);
    chk(mem[63] == 8'h77, "R8", mem[63], 8'h77);
    chk(mem[30] == 8'hF0, "R7", mem[30], 8'hF0);

    // wrap from 63 to 0
    begin_prog();
    put(0, 8'hFE); put(62, 8'h4A); put(63, 8'h94); put(10, 8'h01);
    run(60);
    chk(mem[20] >= 8'd2 && mem[20] == ref_mem[20], "R10", mem[20], ref_mem[20]);

    // random images with random input and halt
    for (int r = 0; r < 4; r++) begin
      begin_prog();
      for (int i = 0; i < 64; i++) put(i, 8'($urandom));
      @(negedge clk);
      @(posedge clk); #2; rst_n = 1;
      repeat (800) begin
        @(posedge clk); #2;
        in_port = 8'($urandom);
        halt = ($urandom % 8) == 0;
      end
      halt = 1;
      repeat (6) @(posedge clk);
      #2;
      for (int i = 0; i < 64; i++) chk(mem[i] == ref_mem[i], "R5", mem[i], ref_mem[i]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule